// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This unit sits beside the execute stage of a five-stage pipeline. It keeps the four status flags (negative, zero, carry, overflow) and decides, for the instruction currently in execute, whether that instruction is allowed to commit. Every instruction class is predicated: branches, data-processing, multiply and load/store. The decision uses the instruction's 4-bit condition field and the flag values already stored.

The unit drives a single execute-enable. When the instruction commits and either asks for a flag update or belongs to the compare/test class, the unit captures the ALU's flag results. The new flags are visible to the following instruction one cycle later. An instruction whose condition is false never writes the flags. The two unused condition encodings evaluate false and raise an error pulse in the same cycle.

The flags travel on a 4-bit vector laid out as [3]=N, [2]=Z, [1]=C, [0]=V. This layout applies to both the ALU input and the flag output.

Top module: `cfp_unit`

## Requirements
- R1: After reset the flag output `flags_o` is 4'b0000.
- R2: Condition 4'b1110 (always) drives `exec_en_o` high whenever `vld_i` is high, whatever the flags hold.
- R3: Simple predicates, each with `vld_i` high, set `exec_en_o` as follows:
  - 4'b0000 when Z=1.
  - 4'b0001 when Z=0.
  - 4'b0010 when C=1.
  - 4'b0100 when N=1.
  - 4'b0101 when N=0.
  - 4'b0110 when V=1.
  - 4'b0111 when V=0.
- R4: Unsigned compound predicates: 4'b1000 is true when C=1 and Z=0. 4'b1001 is true when C=0 or Z=1.
- R5: Signed predicates:
  - 4'b1010 is true when N==V.
  - 4'b1011 is true when N!=V.
  - 4'b1100 is true when Z=0 and N==V.
  - 4'b1101 is true when Z=1 or N!=V.
- R6: Conditions 4'b0011 and 4'b1111 keep `exec_en_o` low. With `vld_i` high they drive `bad_cond_o` high in the same cycle.
- R7: With `vld_i` low, `exec_en_o` and `bad_cond_o` are low and the flags do not change.
- R8: A committing instruction with `setf_i` high loads `alu_flags_i` into `flags_o`, visible after the next rising clock edge.
- R9: A committing instruction with `test_i` high loads `alu_flags_i` into `flags_o` even when `setf_i` is low.
- R10: A committing instruction with `setf_i` and `test_i` both low leaves `flags_o` unchanged.
- R11: An instruction whose condition is false leaves `flags_o` unchanged, even with `setf_i` or `test_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Execute stage holds a live instruction |
| cond_i | input | 4 | Condition field of the instruction |
| alu_flags_i | input | 4 | Flag results from the ALU: {N,Z,C,V} |
| setf_i | input | 1 | Instruction requests a flag update |
| test_i | input | 1 | Instruction is a compare/test operation |
| exec_en_o | output | 1 | Instruction may commit |
| bad_cond_o | output | 1 | Unsupported condition seen on a live instruction |
| flags_o | output | 4 | Stored flags: {N,Z,C,V} |

## Verification
The embedded assertions check the following on every cycle:
- Condition "always" never blocks a live instruction.
- A bubble neither commits nor flags an error.
- An error pulse never coincides with a commit.
- The flag register either reloads from the ALU or holds, exactly as the commit, set-flags and test inputs require.

The truth of the thirteen flag-dependent predicates cannot be checked by a single property. Nor can the flag-to-predicate round trip, where one instruction sets the flags and the next one reads them. Only the bench's sweep of every condition code against every flag pattern, and its pseudo-random instruction stream, show these.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    // Flag vector layout: [3]=N [2]=Z [1]=C [0]=V
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        CND_EQ     = 4'h0,
        CND_NE     = 4'h1,
        CND_CS     = 4'h2,
        CND_RSV_LO = 4'h3,
        CND_MI     = 4'h4,
        CND_PL     = 4'h5,
        CND_VS     = 4'h6,
        CND_VC     = 4'h7,
        CND_HI     = 4'h8,
        CND_LS     = 4'h9,
        CND_GE     = 4'hA,
        CND_LT     = 4'hB,
        CND_GT     = 4'hC,
        CND_LE     = 4'hD,
        CND_AL     = 4'hE,
        CND_RSV_HI = 4'hF
    } cond_e;

endpackage

// File: rtl/cfp_pred_eval.sv
module cfp_pred_eval
    import cfp_pkg::*;
(
    input  flags_t flags_i,
    input  cond_e  cond_i,
    output logic   pass_o,
    output logic   unsup_o
);

    logic signed_ge;

    always_comb begin
        signed_ge = (flags_i.n == flags_i.v);
    end

    always_comb begin
        pass_o  = 1'b0;
        unsup_o = 1'b0;
        unique case (cond_i)
            CND_EQ:     pass_o = flags_i.z;
            CND_NE:     pass_o = !flags_i.z;
            CND_CS:     pass_o = flags_i.c;
            CND_MI:     pass_o = flags_i.n;
            CND_PL:     pass_o = !flags_i.n;
            CND_VS:     pass_o = flags_i.v;
            CND_VC:     pass_o = !flags_i.v;
            CND_HI:     pass_o = flags_i.c && !flags_i.z;
            CND_LS:     pass_o = !flags_i.c || flags_i.z;
            CND_GE:     pass_o = signed_ge;
            CND_LT:     pass_o = !signed_ge;
            CND_GT:     pass_o = !flags_i.z && signed_ge;
            CND_LE:     pass_o = flags_i.z || !signed_ge;
            CND_AL:     pass_o = 1'b1;
            CND_RSV_LO: unsup_o = 1'b1;
            CND_RSV_HI: unsup_o = 1'b1;
        endcase
    end

    // R6: an unsupported code never evaluates true
    always_comb begin
        if (unsup_o) begin
            a_unsup_false_r6: assert (!pass_o);
        end
    end

endmodule

// File: rtl/cfp_commit_ctl.sv
module cfp_commit_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic pass_i,
    input  logic unsup_i,
    input  logic setf_i,
    input  logic test_i,
    output logic exec_en_o,
    output logic flag_wr_o,
    output logic bad_o
);

    always_comb begin
        exec_en_o = vld_i && pass_i;
        bad_o     = vld_i && unsup_i;
        flag_wr_o = exec_en_o && (setf_i || test_i);
    end

    p_bubble_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |-> (!exec_en_o && !bad_o && !flag_wr_o));

    p_bad_blocks_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o |-> !exec_en_o);

    p_fail_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_i |-> !flag_wr_o);

endmodule

// File: rtl/cfp_flag_reg.sv
module cfp_flag_reg
    import cfp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en_i,
    input  flags_t d_i,
    output flags_t q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (wr_en_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/cfp_unit.sv
module cfp_unit
    import cfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    input  logic              setf_i,
    input  logic              test_i,
    output logic              exec_en_o,
    output logic              bad_cond_o,
    output logic [FLAG_W-1:0] flags_o
);

    flags_t cur_flags;
    flags_t alu_flags;
    cond_e  cond;
    logic   pass;
    logic   unsup;
    logic   flag_wr;

    always_comb begin
        alu_flags = flags_t'(alu_flags_i);
        cond      = cond_e'(cond_i);
        flags_o   = cur_flags;
    end

    cfp_pred_eval u_eval (
        .flags_i (cur_flags),
        .cond_i  (cond),
        .pass_o  (pass),
        .unsup_o (unsup)
    );

    cfp_commit_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (vld_i),
        .pass_i    (pass),
        .unsup_i   (unsup),
        .setf_i    (setf_i),
        .test_i    (test_i),
        .exec_en_o (exec_en_o),
        .flag_wr_o (flag_wr),
        .bad_o     (bad_cond_o)
    );

    cfp_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (flag_wr),
        .d_i     (alu_flags),
        .q_o     (cur_flags)
    );

    p_al_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && cond_i == 4'hE) |-> exec_en_o);

    p_setf_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en_o && setf_i) |=> (flags_o == $past(alu_flags_i)));

    p_test_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en_o && test_i) |=> (flags_o == $past(alu_flags_i)));

    p_plain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en_o && !setf_i && !test_i) |=> $stable(flags_o));

    p_fail_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !exec_en_o) |=> $stable(flags_o));

    p_bubble_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(flags_o));

endmodule

// File: tb/tb_cfp_unit.sv
module tb_cfp_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld_i = 1'b0;
    logic [3:0] cond_i = 4'h0;
    logic [3:0] alu_flags_i = 4'h0;
    logic       setf_i = 1'b0;
    logic       test_i = 1'b0;
    logic       exec_en_o;
    logic       bad_cond_o;
    logic [3:0] flags_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    bit [3:0] mdl_flags = 4'h0;
    string    ftag = "R1";
    bit [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    cfp_unit dut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .cond_i(cond_i),
        .alu_flags_i(alu_flags_i), .setf_i(setf_i), .test_i(test_i),
        .exec_en_o(exec_en_o), .bad_cond_o(bad_cond_o), .flags_o(flags_o)
    );

    // Reference predicate: pairs of codes share a base test, odd code inverts it
    function automatic bit ref_pred(bit [3:0] c, bit [3:0] f);
        bit n, z, cy, v, base;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        if (c == 4'd3 || c == 4'd15) return 1'b0;
        if (c == 4'd14) return 1'b1;
        case (c[3:1])
            3'd0:    base = z;
            3'd1:    base = cy;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = cy && !z;
            3'd5:    base = (n == v);
            3'd6:    base = !z && (n == v);
            default: base = 1'b0;
        endcase
        return c[0] ? !base : base;
    endfunction

    function automatic string cond_tag(bit [3:0] c, bit v);
        if (!v) return "R7";
        if (c == 4'd14) return "R2";
        if (c == 4'd3 || c == 4'd15) return "R6";
        if (c < 4'd8) return "R3";
        if (c < 4'd10) return "R4";
        return "R5";
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, bit [3:0] c, bit [3:0] af, bit sf, bit ts);
        bit p, xe, xb;
        @(negedge clk);
        vld_i = v; cond_i = c; alu_flags_i = af; setf_i = sf; test_i = ts;
        #2;
        p  = ref_pred(c, mdl_flags);
        xe = v && p;
        xb = v && (c == 4'd3 || c == 4'd15);
        check(ftag, "flags", flags_o, mdl_flags);
        check(cond_tag(c, v), "exec_en", exec_en_o, xe);
        check(xb ? "R6" : cond_tag(c, v), "bad_cond", bad_cond_o, xb);
        if (!v) ftag = "R7";
        else if (!p) ftag = "R11";
        else if (sf) begin ftag = "R8"; mdl_flags = af; end
        else if (ts) begin ftag = "R9"; mdl_flags = af; end
        else ftag = "R10";
    endtask

    function automatic bit [31:0] nxt(bit [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1", "flags after reset", flags_o, 0);

        // Sweep: load each flag pattern, then try all sixteen conditions
        for (int f = 0; f < 16; f++) begin
            step(1'b1, 4'hE, f[3:0], 1'b1, 1'b0);
            for (int c = 0; c < 16; c++)
                step(1'b1, c[3:0], ~f[3:0], 1'b0, 1'b0);
        end

        // Directed corner cases
        step(1'b1, 4'hE, 4'b0100, 1'b0, 1'b1);   // R9 test loads Z
        step(1'b1, 4'h1, 4'b1111, 1'b1, 1'b1);   // R11 NE fails, no load
        step(1'b1, 4'h3, 4'b1111, 1'b1, 1'b0);   // R6 unsupported, no load
        step(1'b0, 4'hF, 4'b1111, 1'b1, 1'b1);   // R7 bubble
        step(1'b1, 4'h0, 4'b0010, 1'b0, 1'b0);   // R10 EQ passes, no load
        step(1'b1, 4'h0, 4'b1000, 1'b0, 1'b1);   // R9
        step(1'b1, 4'h4, 4'b0000, 1'b1, 1'b0);   // R8 MI passes

        // Pseudo-random instruction stream
        for (int i = 0; i < 600; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[0] | lfsr[1], lfsr[7:4], lfsr[11:8], lfsr[12], lfsr[13] & lfsr[14]);
        end
        step(1'b0, 4'h0, 4'h0, 1'b0, 1'b0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            vectors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule